// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus side of a two-wire serial memory slave. It works on SCL and SDA samples that are already synchronised to the system clock. It finds start and stop conditions and shifts bytes in and out, most significant bit first. It answers with an active-high pull-down enable instead of a driven SDA level. The first byte after a start is a control byte. A fixed device code, three chip-select bits and a direction bit make up that byte. The block compares the chip-select bits with three strap inputs, so up to eight of these slaves can share one bus.

In a write, the byte after the control byte is the word address. It goes to the back end as a pointer load, and every later byte goes out as a data byte. A stop commits the received data. A repeated start drops it instead. In a read, the block takes bytes from the read back end, one request per byte. It keeps doing so while the master acknowledges and stops after a not-acknowledge. While the back end reports a write cycle in progress, the block gives no acknowledge at all, not even for its own address. A master finds out that the cycle has finished by repeating start and control byte until an acknowledge comes back.

Top module: `tws_slave`

## Requirements
- R1: After reset the pull-down enable is low and no output pulse is active.
- R2: A control byte acknowledge works as follows. Bits 7..4 must equal the device code 1010 and bits 3..1 must equal the straps. The pull-down enable then rises on the SCL fall that ends the eighth bit and stays high until the next SCL fall.
- R3: A control byte that fails the device-code or chip-select match gets no acknowledge. Every byte after it, up to the next start or stop, is ignored: no acknowledge and no output pulse.
- R4: While the busy input is high at the end of a byte, that byte gets no acknowledge. Once busy is low, the same control byte is acknowledged.
- R5: A control byte with bit 0 = 0 makes the next byte the word address. The block acknowledges it and gives a one-cycle pointer-load pulse carrying that byte.
- R6: Every further byte of a write is acknowledged and gives a one-cycle data-valid pulse carrying the byte. At most one output pulse is active in any cycle.
- R7: A stop (SDA rising while SCL is high) after at least one data byte gives a one-cycle commit pulse. A stop after only the word address gives none.
- R8: A repeated start (SDA falling while SCL is high) after at least one data byte gives a one-cycle drop pulse and no commit. The control byte that follows is decoded as usual.
- R9: A control byte with bit 0 = 1 starts a read. Each byte is requested with a one-cycle read-request pulse on the SCL fall after an acknowledge, and is driven MSB first. The pull-down enable is the inverse of the bit. The pull-down is released during the master's acknowledge slot. After a not-acknowledge no further byte is requested or driven until a start.
- R10: A start or stop in the middle of a byte resets bit counting. A complete control byte after a mid-byte start is decoded and acknowledged normally.
- R11: The pull-down enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised serial clock |
| sda_i | input | 1 | Synchronised serial data (bus level) |
| strap_i | input | 3 | Chip-select straps |
| busy_i | input | 1 | Write cycle in progress; withholds all acknowledges |
| rd_data_i | input | 8 | Byte offered by the read back end |
| sda_pd_o | output | 1 | SDA pull-down enable, active high |
| ptr_load_o | output | 1 | Word address received (pulse) |
| wr_vld_o | output | 1 | Write data byte received (pulse) |
| byte_o | output | 8 | Byte carried by pointer-load and data-valid pulses |
| rd_req_o | output | 1 | Read byte taken from rd_data_i (pulse) |
| wr_commit_o | output | 1 | Stop after write data: commit (pulse) |
| wr_drop_o | output | 1 | Repeated start after write data: discard (pulse) |

## Verification
The assertions assume a master that changes SDA only while SCL is low, except when it makes a start or a stop. They also assume the bus acts as a wired-AND of the master's SDA and the block's pull-down, so the master can never make a stop while the block holds the line low. Each SCL phase is assumed to last several system clocks, which keeps edge detection unambiguous. The stimulus holds every phase for three clocks and builds SDA as the AND of the master level and the inverted pull-down. It issues starts and stops only from a high SCL with the line released.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_WADDR,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } tws_state_e;
endpackage

// File: rtl/tws_cond.sv
// Line history and bus-condition detection on synchronised SCL/SDA.
module tws_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign rise_o  = scl_i & ~scl_q;
  assign fall_o  = ~scl_i & scl_q;
  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/tws_shift.sv
// Bit counter and receive shifter. Bits are sampled on SCL rise and
// counted on SCL fall; the first fall after a start is not counted.
module tws_shift #(
  parameter int unsigned DW    = 8,
  parameter int unsigned CNT_W = $clog2(DW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             clr_i,
  input  logic             sda_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [DW-1:0]    byte_o,
  output logic             done_o,
  output logic             ack_rise_o,
  output logic             ack_end_o,
  output logic             bit_fall_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(DW);

  logic             armed_q, armed_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [DW-1:0]    sh_q, sh_n;
  logic             cnt_en;

  assign cnt_en = fall_i & armed_q;

  always_comb begin
    armed_n = armed_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    if (clr_i) begin
      armed_n = 1'b0;
      cnt_n   = '0;
    end else begin
      if (rise_i) begin
        armed_n = 1'b1;
        if (cnt_q < ACK_SLOT) sh_n = {sh_q[DW-2:0], sda_i};
      end
      if (cnt_en) cnt_n = (cnt_q == ACK_SLOT) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
    end else begin
      armed_q <= armed_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
    end
  end

  assign cnt_o      = cnt_q;
  assign byte_o     = sh_q;
  assign done_o     = cnt_en & (cnt_q == LAST_BIT);
  assign ack_end_o  = cnt_en & (cnt_q == ACK_SLOT);
  assign ack_rise_o = rise_i & (cnt_q == ACK_SLOT);
  assign bit_fall_o = cnt_en & (cnt_q < LAST_BIT);
endmodule

// File: rtl/tws_slave.sv
module tws_slave import tws_pkg::*; #(
  parameter int unsigned       DW       = 8,
  parameter int unsigned       DEV_W    = 4,
  parameter int unsigned       CS_W     = 3,
  parameter logic [DEV_W-1:0]  DEV_CODE = 4'b1010
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  input  logic [CS_W-1:0] strap_i,
  input  logic            busy_i,
  input  logic [DW-1:0]   rd_data_i,
  output logic            sda_pd_o,
  output logic            ptr_load_o,
  output logic            wr_vld_o,
  output logic [DW-1:0]   byte_o,
  output logic            rd_req_o,
  output logic            wr_commit_o,
  output logic            wr_drop_o
);
  localparam int unsigned CNT_W = $clog2(DW + 1);

  logic             rise, fall, det_start, det_stop;
  logic [CNT_W-1:0] bit_cnt;
  logic [DW-1:0]    rx_byte;
  logic             byte_done, ack_rise, ack_end, bit_fall;
  logic             addr_hit;

  tws_state_e       st_q, st_n;
  logic             ack_q, ack_n;
  logic [DW-1:0]    tx_q, tx_n;
  logic             mack_q, mack_n;
  logic             have_q, have_n;
  logic             load_q, load_n, wr_q, wr_n, rd_q, rd_n, cm_q, cm_n, dr_q, dr_n;
  logic [DW-1:0]    byte_q, byte_n;

  tws_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .rise_o(rise), .fall_o(fall), .start_o(det_start), .stop_o(det_stop)
  );

  tws_shift #(.DW(DW), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .fall_i(fall),
    .clr_i(det_start | det_stop), .sda_i(sda_i),
    .cnt_o(bit_cnt), .byte_o(rx_byte), .done_o(byte_done),
    .ack_rise_o(ack_rise), .ack_end_o(ack_end), .bit_fall_o(bit_fall)
  );

  assign addr_hit = (rx_byte[DW-1 -: DEV_W] == DEV_CODE) && (rx_byte[CS_W:1] == strap_i);

  always_comb begin
    st_n   = st_q;
    ack_n  = ack_q;
    tx_n   = tx_q;
    mack_n = mack_q;
    have_n = have_q;
    byte_n = byte_q;
    load_n = 1'b0;
    wr_n   = 1'b0;
    rd_n   = 1'b0;
    cm_n   = 1'b0;
    dr_n   = 1'b0;
    if (det_stop) begin
      st_n   = ST_IDLE;
      ack_n  = 1'b0;
      cm_n   = have_q;
      have_n = 1'b0;
    end else if (det_start) begin
      st_n   = ST_CTRL;
      ack_n  = 1'b0;
      dr_n   = have_q;
      have_n = 1'b0;
    end else begin
      if (ack_end) begin
        ack_n = 1'b0;
        if (st_q == ST_RDATA) begin
          if (mack_q) begin
            tx_n = rd_data_i;
            rd_n = 1'b1;
          end else begin
            st_n = ST_SKIP;
          end
        end
      end
      if (ack_rise && st_q == ST_RDATA) mack_n = ~sda_i;
      if (bit_fall && st_q == ST_RDATA) tx_n = {tx_q[DW-2:0], 1'b1};
      if (byte_done) begin
        case (st_q)
          ST_CTRL: begin
            if (addr_hit && !busy_i) begin
              ack_n  = 1'b1;
              mack_n = 1'b1;
              st_n   = rx_byte[0] ? ST_RDATA : ST_WADDR;
            end else begin
              st_n = ST_SKIP;
            end
          end
          ST_WADDR, ST_WDATA: begin
            if (!busy_i) begin
              ack_n  = 1'b1;
              byte_n = rx_byte;
              st_n   = ST_WDATA;
              if (st_q == ST_WADDR) begin
                load_n = 1'b1;
              end else begin
                wr_n   = 1'b1;
                have_n = 1'b1;
              end
            end else begin
              st_n = ST_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ack_q  <= 1'b0;
      tx_q   <= '1;
      mack_q <= 1'b0;
      have_q <= 1'b0;
      byte_q <= '0;
      load_q <= 1'b0;
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      cm_q   <= 1'b0;
      dr_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      ack_q  <= ack_n;
      tx_q   <= tx_n;
      mack_q <= mack_n;
      have_q <= have_n;
      byte_q <= byte_n;
      load_q <= load_n;
      wr_q   <= wr_n;
      rd_q   <= rd_n;
      cm_q   <= cm_n;
      dr_q   <= dr_n;
    end
  end

  assign sda_pd_o    = ack_q | ((st_q == ST_RDATA) & (bit_cnt < CNT_W'(DW)) & ~tx_q[DW-1]);
  assign ptr_load_o  = load_q;
  assign wr_vld_o    = wr_q;
  assign byte_o      = byte_q;
  assign rd_req_o    = rd_q;
  assign wr_commit_o = cm_q;
  assign wr_drop_o   = dr_q;
endmodule

// File: rtl/tws_chk.sv
module tws_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_i,
  input logic             sda_i,
  input logic             busy_i,
  input logic             sda_pd_o,
  input logic             ack_en,
  input logic             cond_start,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             ptr_load_o,
  input logic             wr_vld_o,
  input logic             rd_req_o,
  input logic             wr_commit_o,
  input logic             wr_drop_o
);
  // R11
  pd_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pd_o != $past(sda_pd_o)) |-> !$past(scl_i));

  // R2
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ack_en) && $past(scl_i) && scl_i) |-> ack_en);

  // R4
  busy_noack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> !$rose(ack_en));

  // R6
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ptr_load_o, wr_vld_o, rd_req_o, wr_commit_o, wr_drop_o}));

  // R7
  commit_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit_o |-> ($past(scl_i) && $past(sda_i)));

  // R8
  drop_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop_o |-> ($past(scl_i) && !$past(sda_i)));

  // R10
  start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_start |=> (bit_cnt == '0));
endmodule

bind tws_slave tws_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .busy_i(busy_i),
  .sda_pd_o(sda_pd_o), .ack_en(ack_q), .cond_start(det_start), .bit_cnt(bit_cnt),
  .ptr_load_o(ptr_load_o), .wr_vld_o(wr_vld_o), .rd_req_o(rd_req_o),
  .wr_commit_o(wr_commit_o), .wr_drop_o(wr_drop_o)
);

// File: tb/tws_slave_tb.sv
`timescale 1ns/1ps
module tws_slave_tb;
  localparam int H = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_m, sda_m, busy;
  logic [2:0] strap;
  logic [7:0] rptr;
  logic [7:0] rd_data;
  logic       sda_bus;
  logic       sda_pd, ptr_load, wr_vld, rd_req, wr_commit, wr_drop;
  logic [7:0] byte_out;

  int         checks = 0;
  int         errors = 0;
  int         r11_bad = 0;
  bit         done = 0;
  logic       exp_pd;
  int         exp_kind;
  logic [7:0] exp_byte;
  string      cur_req;

  always #2 clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [7:0] a);
    return a * 8'd37 + 8'd11;
  endfunction

  assign rd_data = mem_f(rptr);
  assign sda_bus = sda_m & ~sda_pd;

  tws_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .strap_i(strap),
    .busy_i(busy), .rd_data_i(rd_data), .sda_pd_o(sda_pd), .ptr_load_o(ptr_load),
    .wr_vld_o(wr_vld), .byte_o(byte_out), .rd_req_o(rd_req),
    .wr_commit_o(wr_commit), .wr_drop_o(wr_drop)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %0h exp %0h", req, act, exp);
    end
  endtask

  // Per-clock comparison against the behavioural expectation.
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      checks++;
      if (sda_pd !== exp_pd || ptr_load !== (exp_kind == 1) || wr_vld !== (exp_kind == 2) ||
          rd_req !== (exp_kind == 3) || wr_commit !== (exp_kind == 4) ||
          wr_drop !== (exp_kind == 5) ||
          ((exp_kind == 1 || exp_kind == 2) && byte_out !== exp_byte)) begin
        errors++;
        $display("FAIL %s pd=%b ld=%b wr=%b rd=%b cm=%b dr=%b byte=%h exp pd=%b kind=%0d byte=%h",
                 cur_req, sda_pd, ptr_load, wr_vld, rd_req, wr_commit, wr_drop, byte_out,
                 exp_pd, exp_kind, exp_byte);
      end
      if (sda_pd !== exp_pd && scl_m) r11_bad++;
      if (exp_kind == 3) rptr = rptr + 8'd1;
      exp_kind = 0;
    end
  end

  task automatic step(input logic s, input logic d, input logic pd, input int pk, input logic [7:0] pb);
    @(negedge clk);
    scl_m = s; sda_m = d; exp_pd = pd; exp_kind = pk; exp_byte = pb;
    repeat (H - 1) @(negedge clk);
  endtask

  task automatic start_idle();
    step(1'b1, 1'b0, 1'b0, 0, 8'h00);
  endtask

  task automatic rstart(input bit drop);
    step(1'b0, sda_m, 1'b0, 0, 8'h00);
    step(1'b0, 1'b1, 1'b0, 0, 8'h00);
    step(1'b1, 1'b1, 1'b0, 0, 8'h00);
    step(1'b1, 1'b0, 1'b0, drop ? 5 : 0, 8'h00);
  endtask

  task automatic stop_c(input bit commit);
    step(1'b0, sda_m, 1'b0, 0, 8'h00);
    step(1'b0, 1'b0, 1'b0, 0, 8'h00);
    step(1'b1, 1'b0, 1'b0, 0, 8'h00);
    step(1'b1, 1'b1, 1'b0, commit ? 4 : 0, 8'h00);
  endtask

  task automatic write_byte(input logic [7:0] b, input bit ack, input int pk);
    for (int i = 7; i >= 0; i--) begin
      step(1'b0, sda_m, 1'b0, 0, 8'h00);
      step(1'b0, b[i], 1'b0, 0, 8'h00);
      step(1'b1, b[i], 1'b0, 0, 8'h00);
    end
    step(1'b0, b[0], ack, ack ? pk : 0, b);
    step(1'b0, 1'b1, ack, 0, 8'h00);
    step(1'b1, 1'b1, ack, 0, 8'h00);
    chk(sda_bus == !ack, cur_req, {31'd0, sda_bus}, {31'd0, !ack});
  endtask

  task automatic read_byte(input bit mack, input bit exp_req);
    logic [7:0] eb;
    eb = mem_f(rptr);
    for (int i = 7; i >= 0; i--) begin
      logic pd;
      pd = exp_req ? ~eb[i] : 1'b0;
      step(1'b0, 1'b1, pd, (i == 7 && exp_req) ? 3 : 0, 8'h00);
      step(1'b0, 1'b1, pd, 0, 8'h00);
      step(1'b1, 1'b1, pd, 0, 8'h00);
      if (exp_req) chk(sda_bus == eb[i], cur_req, {31'd0, sda_bus}, {31'd0, eb[i]});
    end
    step(1'b0, 1'b1, 1'b0, 0, 8'h00);
    step(1'b0, !mack, 1'b0, 0, 8'h00);
    step(1'b1, !mack, 1'b0, 0, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; busy = 1'b0; strap = 3'b101;
    rptr = 8'h00; exp_pd = 1'b0; exp_kind = 0; exp_byte = 8'h00; cur_req = "R1";
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(sda_pd == 1'b0, "R1", {31'd0, sda_pd}, 32'd0);
    chk({ptr_load, wr_vld, rd_req, wr_commit, wr_drop} == 5'd0, "R1",
        {27'd0, ptr_load, wr_vld, rd_req, wr_commit, wr_drop}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R5 R6 R7: addressed write, two data bytes, commit on stop
    cur_req = "R2"; start_idle(); write_byte(8'hAA, 1, 0);
    cur_req = "R5"; write_byte(8'h3C, 1, 1);
    cur_req = "R6"; write_byte(8'h5A, 1, 2); write_byte(8'hC3, 1, 2);
    cur_req = "R7"; stop_c(1);

    // R3: chip-select mismatch, then device-code mismatch
    cur_req = "R3"; start_idle(); write_byte(8'hA6, 0, 0); write_byte(8'h11, 0, 0); stop_c(0);
    start_idle(); write_byte(8'hBA, 0, 0); stop_c(0);

    // R4: busy withholds the acknowledge; released busy restores it
    cur_req = "R4"; busy = 1'b1; start_idle(); write_byte(8'hAA, 0, 0); stop_c(0);
    busy = 1'b0; start_idle(); write_byte(8'hAA, 1, 0);
    cur_req = "R7"; write_byte(8'h20, 1, 1); stop_c(0);

    // R8 then R9: write dropped by repeated start, then sequential read
    cur_req = "R8"; start_idle(); write_byte(8'hAA, 1, 0); write_byte(8'h40, 1, 1);
    write_byte(8'h77, 1, 2); rstart(1);
    cur_req = "R9"; rptr = 8'h40; write_byte(8'hAB, 1, 0);
    read_byte(1, 1); read_byte(0, 1); read_byte(1, 0); stop_c(0);
    chk(rptr == 8'h42, "R9", {24'd0, rptr}, 32'h42);

    // R10: start in the middle of a byte
    cur_req = "R10"; start_idle();
    for (int i = 0; i < 3; i++) begin
      step(1'b0, sda_m, 1'b0, 0, 8'h00);
      step(1'b0, i[0], 1'b0, 0, 8'h00);
      step(1'b1, i[0], 1'b0, 0, 8'h00);
    end
    rstart(0); write_byte(8'hAA, 1, 0); stop_c(0);
    repeat (4) @(negedge clk);

    // R11: pull-down never seen changing while SCL high
    chk(r11_bad == 0, "R11", r11_bad, 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule